// File: doc/BRIEF.md
# SD Host Transfer Status Register

This block holds the transfer event status of an SD/MMC host controller. The command engine, the data engine and the descriptor-based DMA walker report events to it on their own input pins. Each event sets a sticky status flag. Software reads the flags through a small word-addressed register port and clears any flag by writing 1 to its bit.

Command completion is found by watching the command-inhibit level for a falling edge. Transfer completion is reported at the end of a transfer. It is also reported when a transfer halts between blocks because software asked for a stop at the block gap.

When a write transfer frees room for a whole block in the buffer, one of two things happens. In normal mode the block sets a buffer-ready flag. In DMA transmit mode it sends a one-cycle request to the system DMA instead. A per-flag enable register gates the flags onto a single level interrupt line.

Top module: `sd_xfer_status`

## Requirements
- R1: Status bit 0 (command done) sets one cycle after `cmd_inhibit` is seen high on one clock edge and low on the next. A level that stays low does not set it again after it has been cleared.
- R2: Status bit 1 (transfer done) sets the cycle after `xfer_done` is high. It also sets the cycle after `gap_halt` is high while `stop_gap_req` is high.
- R3: Status bit 2 (gap stop) sets only the cycle after `gap_halt` and `stop_gap_req` are both high. `gap_halt` without `stop_gap_req` leaves it at 0.
- R4: Status bit 3 (descriptor interrupt) sets the cycle after `desc_irq` is high.
- R5: Status bit 4 (buffer ready) sets the cycle after `blk_space` and `wr_active` are both high while `dma_tx_mode` is low.
- R6: While `dma_tx_mode` is high, the buffer-ready condition leaves bit 4 unchanged. Instead `dma_req` is high for exactly the one cycle after each such event.
- R7: After reset all status and enable bits are 0. A write to address 0 clears each status bit whose write-data bit is 1 and leaves bits written 0 unchanged.
- R8: If a set event and a write-1-clear reach the same status bit in the same cycle, the bit ends up set.
- R9: A write to address 1 loads the enable bits from write-data bits 4:0. `irq` is high whenever any status bit and its enable bit are both 1.
- R10: A read at address 0 returns the status in bits 4:0. A read at address 1 returns the enables in bits 4:0. All other bits, and reads at addresses 2 and 3, return 0. Writes to addresses 2 and 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_inhibit | input | 1 | Command-inhibit level from the command engine |
| xfer_done | input | 1 | Transfer finished strobe |
| gap_halt | input | 1 | Transfer halted at a block gap strobe |
| desc_irq | input | 1 | Descriptor interrupt strobe, issued after that descriptor's data has moved |
| blk_space | input | 1 | One block of buffer space freed strobe |
| wr_active | input | 1 | A block write transfer is in progress |
| stop_gap_req | input | 1 | Software request to stop at the next block gap |
| dma_tx_mode | input | 1 | DMA transmit mode enable |
| reg_addr | input | ADDR_W | Word address of the register port |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from `reg_addr` |
| irq | output | 1 | Combined interrupt level |
| dma_req | output | 1 | One-cycle DMA transmit request |

## Verification
The hardest case to reach from the ports is a hardware set and a software clear landing on the same bit in the same clock cycle. The same holds for a clear that arrives while `cmd_inhibit` stays low. The stimulus builds both cases on purpose, with timed strobes next to register writes. A long random phase then mixes mode changes, gap requests and writes to every address. A behavioural model compares the read data, `irq` and `dma_req` with the design on every clock.

// File: rtl/sd_xfer_status.sv
module sd_xfer_status #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_inhibit,
  input  logic              xfer_done,
  input  logic              gap_halt,
  input  logic              desc_irq,
  input  logic              blk_space,
  input  logic              wr_active,
  input  logic              stop_gap_req,
  input  logic              dma_tx_mode,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              dma_req
);
  localparam int NB = 5;
  localparam logic [ADDR_W-1:0] STS_ADDR = '0;
  localparam logic [ADDR_W-1:0] EN_ADDR  = ADDR_W'(1);

  logic [NB-1:0] sts, en, set_ev, clr;
  logic          inhibit_q;
  logic          gap_stop, buf_free;

  assign gap_stop = gap_halt & stop_gap_req;
  assign buf_free = blk_space & wr_active;

  assign set_ev = {buf_free & ~dma_tx_mode,
                   desc_irq,
                   gap_stop,
                   xfer_done | gap_stop,
                   inhibit_q & ~cmd_inhibit};

  assign clr = (reg_wr && reg_addr == STS_ADDR) ? reg_wdata[NB-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts       <= '0;
      en        <= '0;
      inhibit_q <= 1'b0;
      dma_req   <= 1'b0;
    end else begin
      sts       <= (sts & ~clr) | set_ev;
      inhibit_q <= cmd_inhibit;
      dma_req   <= buf_free & dma_tx_mode;
      if (reg_wr && reg_addr == EN_ADDR) en <= reg_wdata[NB-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == STS_ADDR)     reg_rdata[NB-1:0] = sts;
    else if (reg_addr == EN_ADDR) reg_rdata[NB-1:0] = en;
  end

  assign irq = |(sts & en);

  p_cc_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[0]) |-> (!$past(cmd_inhibit) && $past(cmd_inhibit, 2)));

  p_gap_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[2]) |-> $past(gap_halt && stop_gap_req));

  p_no_bufrdy_in_dma_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[4]) |-> !$past(dma_tx_mode));

  p_dma_req_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> $past(blk_space && wr_active && dma_tx_mode));

  p_clear_takes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == STS_ADDR && reg_wdata[3] && !desc_irq) |=> !sts[3]);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && reg_wr && reg_addr == STS_ADDR && reg_wdata[1]) |=> sts[1]);

  p_mask_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == EN_ADDR && reg_wdata[NB-1:0] == '0) |=> !irq);
endmodule

// File: tb/tb_sd_xfer_status.sv
module tb_sd_xfer_status;
  logic        clk = 0, rst_n = 0;
  logic        cmd_inhibit = 0, xfer_done = 0, gap_halt = 0, desc_irq = 0;
  logic        blk_space = 0, wr_active = 0, stop_gap_req = 0, dma_tx_mode = 0;
  logic [1:0]  reg_addr = 0;
  logic        reg_wr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        irq, dma_req;

  int total = 0, bad = 0;
  bit finished = 0;
  int ms = 0, me = 0, mp = 0, md = 0;

  sd_xfer_status dut (.*);

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; me = 0; mp = 0; md = 0;
    end else begin
      int s, c;
      s = 0;
      if (mp == 1 && !cmd_inhibit) s |= 1;
      if (xfer_done || (gap_halt && stop_gap_req)) s |= 2;
      if (gap_halt && stop_gap_req) s |= 4;
      if (desc_irq) s |= 8;
      if (blk_space && wr_active && !dma_tx_mode) s |= 16;
      c = (reg_wr && reg_addr == 0) ? int'(reg_wdata[4:0]) : 0;
      ms = (ms & ~c & 31) | s;
      if (reg_wr && reg_addr == 1) me = int'(reg_wdata[4:0]);
      md = (blk_space && wr_active && dma_tx_mode) ? 1 : 0;
      mp = cmd_inhibit ? 1 : 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (reg_addr == 0) begin
        chk("R1 cmd done bit", reg_rdata[0], ms[0]);
        chk("R2 xfer done bit", reg_rdata[1], ms[1]);
        chk("R3 gap stop bit", reg_rdata[2], ms[2]);
        chk("R4 desc irq bit", reg_rdata[3], ms[3]);
        chk("R5 buffer ready bit", reg_rdata[4], ms[4]);
      end else if (reg_addr == 1) chk("R9 enable read", reg_rdata[4:0], me[4:0]);
      else chk("R10 unused address read", reg_rdata, 0);
      chk("R10 upper bits", reg_rdata[31:5], 0);
      chk("R9 irq", irq, ((ms & me) != 0));
      chk("R6 dma_req", dma_req, md[0]);
    end
  end

  task automatic tick();
    @(posedge clk); #2;
    xfer_done = 0; gap_halt = 0; desc_irq = 0; blk_space = 0; reg_wr = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk); chk("R7 reset status", reg_rdata, 0);
    reg_addr = 1; @(negedge clk); chk("R7 reset enable", reg_rdata, 0);
    reg_addr = 0;
    cmd_inhibit = 1; tick(); tick();
    cmd_inhibit = 0; tick();
    @(negedge clk); chk("R1 falling edge sets", reg_rdata[0], 1);
    tick(); wr(0, 32'h1); tick(); tick();
    @(negedge clk); chk("R1 steady low no reset", reg_rdata[0], 0);
    desc_irq = 1; tick();
    wr(0, 32'h0); tick();
    @(negedge clk); chk("R7 write zero keeps", reg_rdata[3], 1);
    xfer_done = 1; tick();
    xfer_done = 1; wr(0, 32'h2); tick();
    @(negedge clk); chk("R8 set beats clear", reg_rdata[1], 1);
    wr(0, 32'h1f); tick();
    gap_halt = 1; tick();
    @(negedge clk); chk("R3 no request no gap flag", reg_rdata[2:1], 0);
    stop_gap_req = 1; gap_halt = 1; tick(); stop_gap_req = 0;
    @(negedge clk); chk("R2 gap halt sets done", reg_rdata[2:1], 2'b11);
    wr_active = 1; blk_space = 1; tick();
    @(negedge clk); chk("R5 buffer ready", reg_rdata[4], 1);
    wr(0, 32'h1f); tick();
    dma_tx_mode = 1; blk_space = 1; tick();
    @(negedge clk); chk("R6 request pulse", dma_req, 1);
    chk("R6 no buffer ready", reg_rdata[4], 0);
    tick();
    @(negedge clk); chk("R6 pulse one cycle", dma_req, 0);
    dma_tx_mode = 0; wr_active = 0;
    desc_irq = 1; tick();
    wr(1, 32'h8); tick();
    @(negedge clk); chk("R9 irq enabled", irq, 1);
    wr(1, 32'h0); tick();
    @(negedge clk); chk("R9 irq masked", irq, 0);
    wr(3, 32'hffff_ffff); tick();
    @(negedge clk); chk("R10 high address reads zero", reg_rdata, 0);
    reg_addr = 1; @(negedge clk); chk("R10 high write ignored", reg_rdata, 0);
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 5) == 0) cmd_inhibit = ~cmd_inhibit;
      xfer_done = ($urandom_range(0, 9) == 0);
      gap_halt = ($urandom_range(0, 9) == 0);
      desc_irq = ($urandom_range(0, 9) == 0);
      blk_space = ($urandom_range(0, 4) == 0);
      if ($urandom_range(0, 15) == 0) wr_active = ~wr_active;
      if ($urandom_range(0, 7) == 0) stop_gap_req = ~stop_gap_req;
      if ($urandom_range(0, 31) == 0) dma_tx_mode = ~dma_tx_mode;
      reg_addr = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 3) == 0) begin
        reg_wr = 1;
        reg_wdata = $urandom;
      end
      tick();
    end
    @(negedge clk);
    finish_run();
  end
endmodule